// File: doc/BRIEF.md
# Transmit Jabber Watchdog for a 10 Mb/s Twisted-Pair Port

This block sits between a MAC-side controller and the line driver of a 10 Mb/s twisted-pair port. It watches the transmit request. It measures how long each unbroken transmit request lasts. If a request goes past a configured cycle limit, the block latches into a jabber state. In that state the transmit request and the loopback request towards the line side are both withheld, and a collision indication goes back to the controller. The block stays in jabber until both transmit inputs have been silent without a break for a configured number of cycles. Any activity during that interval restarts the silence count from zero.

While the port is not transmitting and not in jabber, the block counts idle cycles. At a fixed period it raises a one-cycle request for a link integrity pulse. The request is only raised when link integrity is enabled and loopback is disabled. A polarity input inverts the collision and loopback outputs, for controllers that expect them active-low. All limits are parameters counted in clock cycles. The defaults assume a 10 MHz clock: 20 ms transmit limit, 0.5 s silence interval, 16 ms link period.

Top module: `tx_jabber_guard`

## Requirements
- R1: A run of consecutive cycles with `tx_en_i` high trips jabber if it is longer than `LIMIT_CYC` cycles. `jabber_o` goes to 1 in the cycle after the (`LIMIT_CYC`+1)-th high cycle. A run of exactly `LIMIT_CYC` cycles never trips.
- R2: While jabber is active, `tx_en_o` is 0 and the loopback output is held at its inactive level, whatever the inputs are.
- R3: `col_o` is at its active level exactly while `jabber_o` is 1, and at its inactive level otherwise.
- R4: Jabber clears after `UNJAM_CYC` consecutive cycles in which both `tx_en_i` and `tx_data_i` are low. `jabber_o` is 0 in the cycle after the last of those cycles. A cycle with either input high restarts the count from zero.
- R5: `link_pulse_o` is a one-cycle pulse. It comes after every `LINK_CYC` consecutive cycles that are outside jabber with `tx_en_i` low. The first pulse comes one full period after a transmission ends. It is raised only if, at that point, `li_en_i` is 1 and `lpbk_en_i` is 0. The count restarts on any transmit cycle or any jabber cycle.
- R6: With `act_low_i`=1, `col_o` and `lpbk_o` are the logical inverse of their values with `act_low_i`=0. An active level is then 0.
- R7: Outside jabber, `tx_en_o` equals `tx_en_i` and the loopback output is active exactly when `lpbk_en_i` is 1. Both follow their inputs in the same cycle.
- R8: During and right after reset (`rst_n` low, synchronous), `jabber_o` and `link_pulse_o` are 0 and `col_o` is inactive. All counters start from zero, so a new jabber needs a full over-limit run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en_i | input | 1 | Transmit request from the controller |
| tx_data_i | input | 1 | Transmit serial data from the controller |
| li_en_i | input | 1 | Link integrity pulses enabled |
| lpbk_en_i | input | 1 | Loopback requested by the controller |
| act_low_i | input | 1 | 1 = collision and loopback outputs active-low |
| tx_en_o | output | 1 | Gated transmit request to the line side |
| lpbk_o | output | 1 | Gated loopback request, polarity per `act_low_i` |
| col_o | output | 1 | Collision indication, polarity per `act_low_i` |
| link_pulse_o | output | 1 | One-cycle link integrity pulse request |
| jabber_o | output | 1 | 1 while in the jabber state |

## Verification
The assertions assume that the limit parameters are at least 1, with `LINK_CYC` at least 2. They also assume every input is sampled synchronously and is stable across a clock edge. The stimulus respects both: the bench uses small parameter values, and it changes every input just after a rising edge, so each value is held for a whole cycle. The stimulus runs transmissions just below, at and above the limit. It breaks the silence interval with data-only activity, toggles loopback and link enable during idle stretches, and repeats a jabber episode with the inverted polarity.

// File: rtl/jab_pkg.sv
// Package: shared state type for the transmit jabber watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package jab_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_JAB  = 2'd2
    } jab_state_e;

    // Counter width able to hold values 0..n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/jab_run_timer.sv
// Module: jab_run_timer
// Counts consecutive cycles with the run request high.
// trip_o is raised in the cycle that would make the count exceed LIMIT_CYC.
// Assumes: LIMIT_CYC >= 1 and run_i synchronous to clk.
module jab_run_timer #(
    parameter int unsigned LIMIT_CYC = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic trip_o
);
    localparam int unsigned W = jab_pkg::cnt_width(LIMIT_CYC);
    localparam logic [W-1:0] LIM = W'(LIMIT_CYC);

    logic [W-1:0] cnt_q;

    // Trip when the current high cycle comes after LIMIT_CYC earlier ones.
    always_comb trip_o = run_i && (cnt_q == LIM);

    // Count length of the current run; clear on a gap or a trip.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || trip_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    AST_RUN_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);  // R1
    AST_RUN_GAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));  // R1
endmodule

// File: rtl/jab_quiet_timer.sv
// Module: jab_quiet_timer
// While armed, counts consecutive cycles without input activity.
// done_o is raised in the UNJAM_CYC-th silent cycle. Any activity restarts the count.
// Assumes: UNJAM_CYC >= 1.
module jab_quiet_timer #(
    parameter int unsigned UNJAM_CYC = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic busy_i,
    output logic done_o
);
    localparam int unsigned W = jab_pkg::cnt_width(UNJAM_CYC);
    localparam logic [W-1:0] LAST = W'(UNJAM_CYC - 1);

    logic [W-1:0] cnt_q;

    // Silence interval complete in this cycle.
    always_comb done_o = arm_i && !busy_i && (cnt_q == LAST);

    // Track the silent stretch; any activity, disarm or completion clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!arm_i || busy_i || done_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);  // R4
    AST_QUIET_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (cnt_q == '0));  // R4
endmodule

// File: rtl/jab_link_ticker.sv
// Module: jab_link_ticker
// Counts eligible idle cycles. At the end of every LINK_CYC of them it emits a
// one-cycle pulse, if allow_i is high at that point.
// Assumes: LINK_CYC >= 2.
module jab_link_ticker #(
    parameter int unsigned LINK_CYC = 160000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic allow_i,
    output logic pulse_o
);
    localparam int unsigned W = jab_pkg::cnt_width(LINK_CYC);
    localparam logic [W-1:0] LAST = W'(LINK_CYC - 1);

    logic [W-1:0] cnt_q;
    logic         wrap;

    // Period boundary reached in this eligible cycle.
    always_comb wrap = en_i && (cnt_q == LAST);

    // Idle period counter; any non-eligible cycle restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en_i || wrap)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Registered single-cycle pulse request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_o <= 1'b0;
        else
            pulse_o <= wrap && allow_i;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);  // R5
    AST_PULSE_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(allow_i && en_i));  // R5
endmodule

// File: rtl/tx_jabber_guard.sv
// Module: tx_jabber_guard (top)
// Supervises the transmit request: times each run, enters jabber when the run
// is too long, withholds transmit and loopback, and signals a collision while
// in jabber. It leaves jabber after a silent interval and gates the idle link pulses.
// Assumes: LIMIT_CYC >= 1, UNJAM_CYC >= 1, LINK_CYC >= 2, synchronous inputs.
module tx_jabber_guard #(
    parameter int unsigned LIMIT_CYC = 200000,
    parameter int unsigned UNJAM_CYC = 5000000,
    parameter int unsigned LINK_CYC  = 160000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic tx_data_i,
    input  logic li_en_i,
    input  logic lpbk_en_i,
    input  logic act_low_i,
    output logic tx_en_o,
    output logic lpbk_o,
    output logic col_o,
    output logic link_pulse_o,
    output logic jabber_o
);
    import jab_pkg::*;

    jab_state_e st_q, st_d;
    logic       in_jab;
    logic       run_req;
    logic       trip;
    logic       activity;
    logic       unjam_done;
    logic       link_en;
    logic       link_allow;

    always_comb in_jab   = (st_q == ST_JAB);
    always_comb run_req  = tx_en_i && !in_jab;
    always_comb activity = tx_en_i || tx_data_i;
    always_comb link_en  = !in_jab && !tx_en_i;
    always_comb link_allow = li_en_i && !lpbk_en_i;

    jab_run_timer #(.LIMIT_CYC(LIMIT_CYC)) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_req),
        .trip_o (trip)
    );

    jab_quiet_timer #(.UNJAM_CYC(UNJAM_CYC)) u_quiet (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (in_jab),
        .busy_i (activity),
        .done_o (unjam_done)
    );

    jab_link_ticker #(.LINK_CYC(LINK_CYC)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (link_en),
        .allow_i (link_allow),
        .pulse_o (link_pulse_o)
    );

    // Next-state selection for idle, transmitting and jabber.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (tx_en_i) st_d = trip ? ST_JAB : ST_TX;
            ST_TX:   if (trip) st_d = ST_JAB;
                     else if (!tx_en_i) st_d = ST_IDLE;
            ST_JAB:  if (unjam_done) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Output gating and polarity selection.
    always_comb begin
        tx_en_o  = tx_en_i && !in_jab;
        lpbk_o   = (lpbk_en_i && !in_jab) ^ act_low_i;
        col_o    = in_jab ^ act_low_i;
        jabber_o = in_jab;
    end

    AST_JAB_ENTRY_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jabber_o) |-> $past(tx_en_i));  // R1
    AST_TX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        jabber_o |-> !tx_en_o);  // R2
    AST_LPBK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        jabber_o |-> (lpbk_o == act_low_i));  // R2
    AST_EXIT_AFTER_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jabber_o) |-> $past(!tx_en_i && !tx_data_i));  // R4
    AST_NO_PULSE_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_i |=> !link_pulse_o);  // R5
endmodule

// File: tb/tb_tx_jabber_guard.sv
module tb_tx_jabber_guard;
    localparam int PERIOD = 10;
    localparam int LIMIT  = 12;
    localparam int UNJAM  = 20;
    localparam int LINK   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, tx_data = 1'b0, li_en = 1'b1, lpbk_en = 1'b0, act_low = 1'b0;
    logic tx_en_o, lpbk_o, col_o, link_pulse_o, jabber_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state.
    bit m_jab = 0, m_pulse = 0;
    int m_run = 0, m_quiet = 0, m_idle = 0;

    always #(PERIOD/2) clk = ~clk;

    tx_jabber_guard #(.LIMIT_CYC(LIMIT), .UNJAM_CYC(UNJAM), .LINK_CYC(LINK)) dut (
        .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .tx_data_i(tx_data),
        .li_en_i(li_en), .lpbk_en_i(lpbk_en), .act_low_i(act_low),
        .tx_en_o(tx_en_o), .lpbk_o(lpbk_o), .col_o(col_o),
        .link_pulse_o(link_pulse_o), .jabber_o(jabber_o)
    );

    // Reference model: advances on each rising edge from pre-edge inputs.
    always @(posedge clk) begin
        bit old_jab;
        old_jab = m_jab;
        if (!rst_n) begin
            m_jab = 0; m_pulse = 0; m_run = 0; m_quiet = 0; m_idle = 0;
        end else begin
            if (!old_jab && !tx_en) begin
                if (m_idle == LINK - 1) begin
                    m_pulse = li_en && !lpbk_en; m_idle = 0;
                end else begin
                    m_pulse = 0; m_idle++;
                end
            end else begin
                m_pulse = 0; m_idle = 0;
            end
            if (old_jab) begin
                m_run = 0;
                if (tx_en || tx_data) m_quiet = 0;
                else if (m_quiet == UNJAM - 1) begin m_jab = 0; m_quiet = 0; end
                else m_quiet++;
            end else if (tx_en) begin
                if (m_run == LIMIT) begin m_jab = 1; m_run = 0; m_quiet = 0; end
                else m_run++;
            end else m_run = 0;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model in the middle of each cycle.
    always @(negedge clk) begin
        if (!done) begin
            chk(m_jab ? "R2" : "R7", "tx_en_o", tx_en_o, tx_en && !m_jab);
            chk(act_low ? "R6" : "R2/R7", "lpbk_o", lpbk_o, (lpbk_en && !m_jab) ^ act_low);
            chk(act_low ? "R6" : "R3", "col_o", col_o, m_jab ^ act_low);
            chk("R1/R4", "jabber_o", jabber_o, m_jab);
            chk("R5", "link_pulse_o", link_pulse_o, m_pulse);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic drive(input logic en, input logic d);
        tx_en = en; tx_data = d;
    endtask

    task automatic burst(input int n);
        for (int i = 0; i < n; i++) begin
            drive(1'b1, i[0]); cyc(1);
        end
        drive(1'b0, 1'b0);
    endtask

    int pulses;

    initial begin
        cyc(3);
        // R8: reset state
        chk("R8", "jabber_o in reset", jabber_o, 1'b0);
        chk("R8", "col_o in reset", col_o, 1'b0);
        chk("R8", "link_pulse_o in reset", link_pulse_o, 1'b0);
        rst_n = 1'b1;
        // R5: idle pulses with link enabled
        pulses = 0;
        for (int i = 0; i < 3 * LINK + 2; i++) begin cyc(1); if (link_pulse_o) pulses++; end
        checks++; if (pulses != 3) begin errors++; $display("FAIL R5 pulse count: actual=%0d expected=3", pulses); end
        // R7: short transmission passes through
        burst(5); cyc(LINK + 3);
        // R1: exactly LIMIT cycles does not trip
        burst(LIMIT); cyc(2);
        chk("R1", "no trip at limit", jabber_o, 1'b0);
        // R5: loopback on suppresses pulses, then link disabled
        lpbk_en = 1'b1; cyc(2 * LINK + 2);
        lpbk_en = 1'b0; li_en = 1'b0; cyc(2 * LINK);
        li_en = 1'b1;
        // R1/R2/R3: over-limit run trips
        lpbk_en = 1'b1;
        burst(LIMIT + 6);
        chk("R1", "trip over limit", jabber_o, 1'b1);
        // R4: data activity during silence restarts the count
        cyc(UNJAM - 3); drive(1'b0, 1'b1); cyc(1); drive(1'b0, 1'b0);
        cyc(UNJAM - 1);
        chk("R4", "still jabber after restart", jabber_o, 1'b1);
        cyc(2);
        chk("R4", "exit after silence", jabber_o, 1'b0);
        lpbk_en = 1'b0; cyc(LINK + 2);
        // R6: inverted polarity across a second jabber episode
        act_low = 1'b1; lpbk_en = 1'b1; cyc(2);
        burst(LIMIT + 1);
        chk("R6", "col_o active-low in jabber", col_o, 1'b0);
        cyc(UNJAM + 2);
        chk("R6", "col_o inactive-high", col_o, 1'b1);
        act_low = 1'b0; lpbk_en = 1'b0;
        // R8: reset mid-run clears the run counter
        drive(1'b1, 1'b0); cyc(LIMIT - 2);
        rst_n = 1'b0; cyc(2); rst_n = 1'b1;
        cyc(LIMIT);
        chk("R8", "counter cleared by reset", jabber_o, 1'b0);
        drive(1'b0, 1'b0); cyc(UNJAM + LINK);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule